// File: doc/BRIEF.md
# Line BIP-24 Parity Checker

This block checks line-level parity on a byte-serial 155 Mb/s receive stream that has already been framed and descrambled. Every byte marked as covered is folded into an even-parity word 24 bits wide. Three lanes of eight bits are filled in rotation, and the rotation restarts on each frame-start strobe. During the following frame, three strobed bytes carry the parity that the far end computed. These bytes are captured, and at the next frame start they are compared against the locally computed word.

The number of mismatching bit positions (0 to 24) is shown for one cycle on a per-frame output, for use by downstream error-rate monitors. A running 17-bit accumulator adds either that number (bit mode) or a single count for any errored frame (block mode). On each rising edge of the latch control, the accumulator is copied into a readable holding register. The accumulator then restarts from the contribution of that same cycle, so no error is lost at the boundary.

Top module: `bip24_line_check`

## Requirements
- R1: Parity is even parity per bit position. The first covered byte after a frame start feeds lane 0 (bits 23:16), the next feeds lane 1 (bits 15:8), the next feeds lane 2 (bits 7:0), and the rotation then repeats.
- R2: The parity captured in a frame (the first three bytes with `par_strobe` high, in lane order 0, 1, 2) is compared at the next frame start with the word computed over the frame before it. No comparison is made unless a full computed frame exists and three parity bytes were captured.
- R3: On a comparison, `frame_errs_vld` is high for exactly the cycle after the edge that sampled `frame_start`, and `frame_errs` holds the mismatch population count (0 to 24) until the next comparison.
- R4: With `count_mode` = 0 (bit mode), each comparison adds its mismatch count to the accumulator.
- R5: With `count_mode` = 1 (block mode), each comparison with any mismatch adds exactly one.
- R6: `err_hold` changes only after a clock edge at which `latch_ctl` is 1 and was 0 at the previous edge. Holding `latch_ctl` high gives no further updates.
- R7: On a latch edge, `err_hold` takes the accumulator value from before that edge. The accumulator restarts from that cycle's contribution, or from zero if there is none.
- R8: The accumulator, and so `err_hold`, saturates at 131071 and never wraps.
- R9: During reset, `err_hold`, `frame_errs` and `frame_errs_vld` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| frame_start | input | 1 | High on the first byte of a frame |
| cover_en | input | 1 | Byte is included in the parity |
| par_strobe | input | 1 | Byte is one of the three received parity bytes |
| count_mode | input | 1 | 0 counts errored bits, 1 counts errored frames |
| latch_ctl | input | 1 | Rising edge copies the accumulator to `err_hold` |
| frame_errs | output | 5 | Mismatch count of the last comparison |
| frame_errs_vld | output | 1 | One-cycle pulse for a new comparison |
| err_hold | output | 17 | Readable holding register |

## Verification
The properties assume that `frame_start` is a single-cycle strobe and that `latch_ctl` is synchronous to `clk`. They also assume that parity strobes after the third one in a frame are simply ignored. The latch and accumulator properties rely only on the registered history of `latch_ctl`, so they hold for any latch timing, including a rise in the same cycle as a frame start. The stimulus uses 12-byte frames: three uncovered bytes, then three covered parity bytes, then six covered payload bytes. It changes `count_mode` and `latch_ctl` only between frames or exactly on a frame start.

// File: rtl/bip24_pkg.sv
package bip24_pkg;
  localparam int unsigned LANE_CNT = 3;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned PAR_W    = LANE_CNT * LANE_W;
  localparam int unsigned FERR_W   = $clog2(PAR_W + 1);
  localparam int unsigned HOLD_W   = 17;

  typedef enum logic {
    CNT_BITS   = 1'b0,
    CNT_BLOCKS = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/bip24_lane_calc.sv
module bip24_lane_calc #(
  parameter int LANES  = 3,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BYTE_W-1:0]         rx_byte,
  input  logic                      frame_start,
  input  logic                      cover_en,
  output logic [LANES*BYTE_W-1:0]   calc_prev,
  output logic                      prev_ok
);
  localparam int PAR_W = LANES * BYTE_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [BYTE_W-1:0] lane_q [LANES];
  logic [BYTE_W-1:0] lane_d [LANES];
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PAR_W-1:0]  cur_flat, prev_q, prev_d;
  logic              started_q, started_d, ok_q, ok_d;
  logic              upd_en;

  // lane 0 occupies the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_flat
    assign cur_flat[PAR_W-1-g*BYTE_W -: BYTE_W] = lane_q[g];
  end

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(LANES - 1)) ? '0 : i + 1'b1;
  endfunction

  assign upd_en = frame_start | cover_en;

  always_comb begin
    lane_d    = lane_q;
    idx_d     = idx_q;
    prev_d    = prev_q;
    started_d = started_q;
    ok_d      = ok_q;
    if (frame_start) begin
      prev_d    = cur_flat;
      ok_d      = started_q;
      started_d = 1'b1;
      for (int i = 0; i < LANES; i++) lane_d[i] = '0;
      idx_d = '0;
      if (cover_en) begin
        lane_d[0] = rx_byte;
        idx_d     = step_idx('0);
      end
    end else if (cover_en) begin
      lane_d[idx_q] = lane_q[idx_q] ^ rx_byte;
      idx_d         = step_idx(idx_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
      idx_q     <= '0;
      prev_q    <= '0;
      started_q <= 1'b0;
      ok_q      <= 1'b0;
    end else if (upd_en) begin
      for (int i = 0; i < LANES; i++) lane_q[i] <= lane_d[i];
      idx_q     <= idx_d;
      prev_q    <= prev_d;
      started_q <= started_d;
      ok_q      <= ok_d;
    end
  end

  assign calc_prev = prev_q;
  assign prev_ok   = ok_q;
endmodule

// File: rtl/bip24_rx_capture.sv
module bip24_rx_capture #(
  parameter int LANES  = 3,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTE_W-1:0]       rx_byte,
  input  logic                    frame_start,
  input  logic                    par_strobe,
  output logic [LANES*BYTE_W-1:0] rx_par,
  output logic                    rx_full
);
  localparam int PAR_W = LANES * BYTE_W;
  localparam int CNT_W = $clog2(LANES + 1);

  logic [BYTE_W-1:0] byte_q [LANES];
  logic [BYTE_W-1:0] byte_d [LANES];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              upd_en;

  for (genvar g = 0; g < LANES; g++) begin : g_flat
    assign rx_par[PAR_W-1-g*BYTE_W -: BYTE_W] = byte_q[g];
  end

  assign upd_en  = frame_start | par_strobe;
  assign rx_full = (cnt_q == CNT_W'(LANES));

  always_comb begin
    byte_d = byte_q;
    cnt_d  = cnt_q;
    if (frame_start) begin
      for (int i = 0; i < LANES; i++) byte_d[i] = '0;
      cnt_d = '0;
      if (par_strobe) begin
        byte_d[0] = rx_byte;
        cnt_d     = CNT_W'(1);
      end
    end else if (par_strobe && !rx_full) begin
      byte_d[cnt_q] = rx_byte;
      cnt_d         = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) byte_q[i] <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < LANES; i++) byte_q[i] <= byte_d[i];
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bip24_err_count.sv
module bip24_err_count #(
  parameter int PAR_W  = 24,
  parameter int HOLD_W = 17
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          cmp_ok,
  input  logic [PAR_W-1:0]              calc_par,
  input  logic [PAR_W-1:0]              rx_par,
  input  logic                          count_mode,
  input  logic                          latch_ctl,
  output logic [$clog2(PAR_W+1)-1:0]    frame_errs,
  output logic                          frame_errs_vld,
  output logic [HOLD_W-1:0]             err_hold,
  output logic [HOLD_W-1:0]             acc_val
);
  localparam int FERR_W = $clog2(PAR_W + 1);
  localparam logic [HOLD_W-1:0] SAT_VAL = {HOLD_W{1'b1}};

  logic [PAR_W-1:0]  mism;
  logic [FERR_W-1:0] pc;
  logic              fire, latch_edge, latch_q;
  logic [HOLD_W-1:0] contrib, acc_q, acc_d, hold_q, hold_d, sat_sum;
  logic [HOLD_W:0]   sum;
  logic [FERR_W-1:0] fe_q, fe_d;
  logic              vld_q, vld_d;
  logic              acc_en;

  assign mism       = calc_par ^ rx_par;
  assign fire       = frame_start & cmp_ok;
  assign latch_edge = latch_ctl & ~latch_q;
  assign acc_en     = fire | latch_edge;

  always_comb begin
    pc = '0;
    for (int i = 0; i < PAR_W; i++) pc = pc + FERR_W'(mism[i]);
  end

  always_comb begin
    if (!fire)
      contrib = '0;
    else if (count_mode == bip24_pkg::CNT_BLOCKS)
      contrib = HOLD_W'(|mism);
    else
      contrib = HOLD_W'(pc);
    sum     = {1'b0, acc_q} + {1'b0, contrib};
    sat_sum = sum[HOLD_W] ? SAT_VAL : sum[HOLD_W-1:0];
    acc_d   = latch_edge ? contrib : sat_sum;
    hold_d  = acc_q;
    fe_d    = pc;
    vld_d   = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      hold_q  <= '0;
      fe_q    <= '0;
      vld_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      latch_q <= latch_ctl;
      vld_q   <= vld_d;
      if (acc_en)     acc_q  <= acc_d;
      if (latch_edge) hold_q <= hold_d;
      if (fire)       fe_q   <= fe_d;
    end
  end

  assign frame_errs     = fe_q;
  assign frame_errs_vld = vld_q;
  assign err_hold       = hold_q;
  assign acc_val        = acc_q;
endmodule

// File: rtl/bip24_line_check.sv
module bip24_line_check #(
  parameter int LANES  = bip24_pkg::LANE_CNT,
  parameter int BYTE_W = bip24_pkg::LANE_W,
  parameter int HOLD_W = bip24_pkg::HOLD_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [BYTE_W-1:0]                    rx_byte,
  input  logic                                 frame_start,
  input  logic                                 cover_en,
  input  logic                                 par_strobe,
  input  logic                                 count_mode,
  input  logic                                 latch_ctl,
  output logic [$clog2(LANES*BYTE_W+1)-1:0]    frame_errs,
  output logic                                 frame_errs_vld,
  output logic [HOLD_W-1:0]                    err_hold
);
  localparam int PAR_W = LANES * BYTE_W;

  logic [PAR_W-1:0]  calc_prev, rx_par;
  logic              prev_ok, rx_full, cmp_ok;
  logic [HOLD_W-1:0] acc_val;

  bip24_lane_calc #(.LANES(LANES), .BYTE_W(BYTE_W)) calc_i (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .frame_start(frame_start),
    .cover_en(cover_en), .calc_prev(calc_prev), .prev_ok(prev_ok)
  );

  bip24_rx_capture #(.LANES(LANES), .BYTE_W(BYTE_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .frame_start(frame_start),
    .par_strobe(par_strobe), .rx_par(rx_par), .rx_full(rx_full)
  );

  assign cmp_ok = prev_ok & rx_full;

  bip24_err_count #(.PAR_W(PAR_W), .HOLD_W(HOLD_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmp_ok(cmp_ok),
    .calc_par(calc_prev), .rx_par(rx_par), .count_mode(count_mode),
    .latch_ctl(latch_ctl), .frame_errs(frame_errs),
    .frame_errs_vld(frame_errs_vld), .err_hold(err_hold), .acc_val(acc_val)
  );
endmodule

// File: rtl/bip24_line_check_sva.sv
module bip24_line_check_sva #(
  parameter int PAR_W  = bip24_pkg::PAR_W,
  parameter int FERR_W = bip24_pkg::FERR_W,
  parameter int HOLD_W = bip24_pkg::HOLD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              latch_ctl,
  input logic [FERR_W-1:0] frame_errs,
  input logic              frame_errs_vld,
  input logic [HOLD_W-1:0] err_hold,
  input logic [HOLD_W-1:0] acc_val
);
  logic [HOLD_W-1:0] hold_q, acc_q;
  logic              lat_q1, lat_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      acc_q  <= '0;
      lat_q1 <= 1'b0;
      lat_q2 <= 1'b0;
    end else begin
      hold_q <= err_hold;
      acc_q  <= acc_val;
      lat_q1 <= latch_ctl;
      lat_q2 <= lat_q1;
    end
  end

  // R3
  frame_errs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_errs_vld |-> (frame_errs <= FERR_W'(PAR_W)));

  // R3
  vld_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_errs_vld |-> $past(frame_start));

  // R6
  hold_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hold != hold_q) |-> (lat_q1 && !lat_q2));

  // R7
  hold_takes_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q1 && !lat_q2) |-> (err_hold == acc_q));

  // R8
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_val < acc_q) |-> (lat_q1 && !lat_q2));
endmodule

bind bip24_line_check bip24_line_check_sva chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .latch_ctl(latch_ctl),
  .frame_errs(frame_errs), .frame_errs_vld(frame_errs_vld),
  .err_hold(err_hold), .acc_val(acc_val)
);

// File: tb/bip24_line_check_tb_top.sv
module bip24_line_check_tb_top;
  localparam int MAXV = 131071;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_byte;
  logic        frame_start, cover_en, par_strobe, count_mode, latch_ctl;
  logic [4:0]  frame_errs;
  logic        frame_errs_vld;
  logic [16:0] err_hold;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bip24_line_check dut_i (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .frame_start(frame_start),
    .cover_en(cover_en), .par_strobe(par_strobe), .count_mode(count_mode),
    .latch_ctl(latch_ctl), .frame_errs(frame_errs),
    .frame_errs_vld(frame_errs_vld), .err_hold(err_hold)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [23:0] m_cur, m_prev, m_rx;
  int        m_ci, m_rxcnt, m_acc, e_hold, e_fe;
  bit        m_started, m_prev_ok, m_lat, e_vld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_prev = 0; m_rx = 0; m_ci = 0; m_rxcnt = 0;
      m_acc = 0; e_hold = 0; e_fe = 0; m_started = 0; m_prev_ok = 0;
      m_lat = 0; e_vld = 0;
    end else begin
      int contrib;
      contrib = 0;
      e_vld = 0;
      if (frame_start && m_prev_ok && m_rxcnt == 3) begin
        e_fe  = $countones(m_prev ^ m_rx);
        e_vld = 1;
        contrib = count_mode ? (e_fe != 0 ? 1 : 0) : e_fe;
      end
      if (latch_ctl && !m_lat) begin
        e_hold = m_acc;
        m_acc  = contrib;
      end else begin
        m_acc = m_acc + contrib;
        if (m_acc > MAXV) m_acc = MAXV;
      end
      m_lat = latch_ctl;
      if (frame_start) begin
        m_prev = m_cur; m_prev_ok = m_started; m_started = 1;
        m_cur = 0; m_ci = 0; m_rxcnt = 0; m_rx = 0;
      end
      if (cover_en) begin
        m_cur = m_cur ^ (24'(rx_byte) << (8 * (2 - m_ci)));
        m_ci = (m_ci + 1) % 3;
      end
      if (par_strobe && m_rxcnt < 3) begin
        m_rx = m_rx | (24'(rx_byte) << (8 * (2 - m_rxcnt)));
        m_rxcnt++;
      end
    end
  end

  int last_fe = 0;
  int vld_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(frame_errs_vld == e_vld, "R3 vld", int'(frame_errs_vld), int'(e_vld));
      if (e_vld) chk(int'(frame_errs) == e_fe, "R1 frame_errs", int'(frame_errs), e_fe);
      chk(int'(err_hold) == e_hold, count_mode ? "R5 hold" : "R4 hold", int'(err_hold), e_hold);
      if (frame_errs_vld) begin
        last_fe = int'(frame_errs);
        vld_cnt++;
      end
    end
  end

  // stimulus generator
  bit [23:0] gen_cur = 0;
  bit [23:0] gen_prev = 0;

  task automatic send_frame(input bit [23:0] mask, input bit with_par, input bit latch_at_start);
    for (int p = 0; p < 12; p++) begin
      bit [7:0] b;
      bit [23:0] pw;
      if (p == 0) begin
        gen_prev = gen_cur;
        gen_cur  = 0;
        if (latch_at_start) latch_ctl = 1'b1;
      end
      pw = gen_prev ^ mask;
      frame_start = (p == 0);
      cover_en    = (p >= 3);
      par_strobe  = with_par && (p >= 3) && (p <= 5);
      if (par_strobe) b = pw[8*(2-(p-3)) +: 8];
      else            b = 8'($urandom);
      rx_byte = b;
      if (p >= 3) gen_cur = gen_cur ^ (24'(b) << (8 * (2 - ((p - 3) % 3))));
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    frame_start = 0; cover_en = 0; par_strobe = 0; rx_byte = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic latch_pulse();
    latch_ctl = 1'b1;
    @(negedge clk);
    latch_ctl = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int v0;
    rst_n = 0; rx_byte = 0; frame_start = 0; cover_en = 0; par_strobe = 0;
    count_mode = 0; latch_ctl = 0;
    repeat (3) @(negedge clk);
    chk(err_hold == 0, "R9 hold in reset", int'(err_hold), 0);
    chk(frame_errs == 0, "R9 frame_errs in reset", int'(frame_errs), 0);
    chk(frame_errs_vld == 0, "R9 vld in reset", int'(frame_errs_vld), 0);
    rst_n = 1;
    idle(2);

    // bit mode: first frame never compared, then 0+1+24+8+2
    send_frame(24'hFFFFFF, 1, 0);
    send_frame(24'h000000, 1, 0);
    send_frame(24'h000001, 1, 0);
    send_frame(24'hFFFFFF, 1, 0);
    send_frame(24'h0F0F00, 1, 0);
    send_frame(24'h800001, 1, 0);
    send_frame(24'h000000, 1, 0);
    idle(2);
    chk(last_fe == 2, "R3 last frame_errs", last_fe, 2);
    chk(vld_cnt == 5, "R2 comparison count", vld_cnt, 5);
    latch_pulse();
    chk(err_hold == 35, "R4 bit total", int'(err_hold), 35);

    send_frame(24'h000007, 1, 0);
    send_frame(24'h000000, 1, 0);
    send_frame(24'h000000, 1, 0);
    idle(2);
    chk(err_hold == 35, "R6 no latch edge", int'(err_hold), 35);
    latch_ctl = 1; idle(2);
    chk(err_hold == 3, "R4 second total", int'(err_hold), 3);
    send_frame(24'hFFFFFF, 1, 0);
    send_frame(24'h000000, 1, 0);
    send_frame(24'h000000, 1, 0);
    idle(2);
    chk(err_hold == 3, "R6 level held high", int'(err_hold), 3);
    latch_ctl = 0; idle(2);
    latch_ctl = 1; idle(2);
    chk(err_hold == 24, "R4 after re-arm", int'(err_hold), 24);
    latch_ctl = 0; idle(2);

    // block mode, latch coincident with a counted frame
    count_mode = 1; idle(1);
    send_frame(24'h000100, 1, 0);
    send_frame(24'h00FF00, 1, 0);
    send_frame(24'h000000, 1, 0);
    send_frame(24'h010000, 1, 0);
    send_frame(24'h000000, 1, 1);
    idle(2);
    chk(err_hold == 2, "R5 block total", int'(err_hold), 2);
    send_frame(24'h000000, 1, 0);
    idle(1);
    latch_ctl = 0; idle(2);
    latch_ctl = 1; idle(2);
    chk(err_hold == 1, "R7 boundary contribution kept", int'(err_hold), 1);
    latch_ctl = 0; idle(2);

    // frame without parity strobes is not compared
    count_mode = 0; idle(1);
    v0 = vld_cnt;
    send_frame(24'h000000, 0, 0);
    send_frame(24'h000000, 1, 0);
    idle(2);
    chk(vld_cnt - v0 == 1, "R2 missing parity skips compare", vld_cnt - v0, 1);

    // saturation
    latch_pulse();
    for (int k = 0; k < 5462; k++) send_frame(24'hFFFFFF, 1, 0);
    send_frame(24'h000000, 1, 0);
    idle(2);
    latch_pulse();
    chk(err_hold == 17'(MAXV), "R8 saturation", int'(err_hold), MAXV);
    latch_pulse();
    chk(err_hold == 0, "R7 restart after latch", int'(err_hold), 0);
    idle(2);
    finish_run();
  end
endmodule